// File: doc/BRIEF.md
# I2C Register-Bank Slave with Per-Byte Clock Stretching

This block is an I2C target device that holds a small bank of byte-wide registers behind one fixed 7-bit bus address. It watches the bus through oversampled copies of the clock and data lines, and it answers by pulling either line low through two open-drain enables. The bus stays wired-AND outside the block. A write transaction loads an internal register pointer with its first data byte. Each further byte lands in the register the pointer selects, and the pointer then moves to the next register. A read, either after a repeated START or in a transaction of its own, streams registers out starting at the current pointer.

After every byte it accepts, the slave keeps the clock line low for a programmable number of system clock cycles, as a device with processing latency would. Start and stop conditions are recognised only while the synchronised clock line is high. A data-line fall during the slave's own clock hold is therefore just a data transition. A master that begins a START before the slave has released the clock gets its next byte treated as write data, not as a new address.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After a START, a byte whose upper seven bits equal OWN_ADDR (default 0x3A) is acknowledged by driving SDA low through the ninth clock. Its bit 0 selects the direction: 1 reads and 0 writes.
- R2: After a START whose address byte does not match, the slave drives neither line until the next START. A later START carrying the matching address is served normally.
- R3: In a write transaction, the first data byte loads the pointer from its low log2(NREG) bits. Each later byte is stored at the pointer, which then steps by one and wraps from NREG-1 to 0. Every write data byte is acknowledged.
- R4: After the ninth-clock falling edge of every acknowledged received byte, the slave holds SCL low for exactly stretch_len system clock cycles. Received bytes include both address directions and write data. A value of 0 disables the hold. stretch_len must be stable while a transfer is in progress.
- R5: A repeated START followed by the read address returns register contents starting at the pointer set earlier in the same transaction.
- R6: The pointer survives a STOP, so a read in a fresh transaction starts where the previous transaction left it.
- R7: While transmitting, the pointer steps by one after each byte sent and wraps from NREG-1 to 0.
- R8: The slave sends further bytes while the master acknowledges. After a byte the master does not acknowledge, it releases SDA, so any further clocks before STOP read as ones.
- R9: An SDA fall while the slave is holding SCL low is not a START. The next eight bits are stored as ordinary write data and acknowledged.
- R10: A STOP returns the slave to idle. Bytes clocked afterwards without a START get no acknowledge, no clock hold and no pointer change.
- R11: After reset, both line enables are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| stretch_len | input | STR_W | Clock-hold length in system clock cycles after each received byte |
| scl_oe | output | 1 | High pulls the bus clock line low |
| sda_oe | output | 1 | High pulls the bus data line low |

## Verification
The central corner case is a master that lowers SDA while the slave still holds the clock and then clocks the read address. A design that accepts that edge as a START would switch to transmit mode, so the register would never receive the address byte and the readback would expose it. The hold length is measured on every received byte, with both address directions included and zero tested. An off-by-one counter, or a missing hold after the read address, shows up as a wrong length or a missing hold. The tests also cover reads that wrap past the last register and a read that the master ends with a NACK and then clocks further: a slave that keeps driving shows zeros where ones belong. Finally, traffic after a STOP without a START and traffic for a foreign address are both followed by a fresh read. That read shows whether the pointer moved.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C register-bank slave.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package i2cs_pkg;

    // Protocol phase of the slave controller.
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for a START
        PH_RECV,    // shifting in an address or data byte
        PH_ACK,     // driving acknowledge through the ninth clock
        PH_HOLD,    // holding SCL low after a received byte
        PH_SEND,    // shifting a register byte out
        PH_MACK,    // sampling the master's acknowledge
        PH_SKIP     // not addressed: lines released until next START
    } phase_t;

endpackage

// File: rtl/i2cs_lines.sv
// Bus line conditioner: synchronises SCL and SDA into the clk domain and
// derives clock edges plus START/STOP events from the synchronised values.
// Assumes SYNC_STAGES >= 2 and that bus edges are many clk cycles apart.
module i2cs_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;   // index 0 = SCL, index 1 = SDA

    logic [NLINES-1:0] pins;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev;

    assign pins = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;

        // Shift the raw line through the synchroniser chain; idle value is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], pins[g]};
        end

        assign cur[g] = chain[SYNC_STAGES-1];
    end

    // Keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign start_det = prev[0] & cur[0] & prev[1] & ~cur[1];
    assign stop_det  = prev[0] & cur[0] & ~prev[1] & cur[1];

endmodule

// File: rtl/i2cs_bank.sv
// Register bank: NREG byte registers with one registered write port and one
// combinational read port. Assumes NREG is a power of two.
module i2cs_bank #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NREG];

    // Clear all registers on reset, otherwise store the write-port byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R3: a byte written through the port is held in the addressed register.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/i2cs_ctrl.sv
// Protocol controller: decodes address and data bytes, drives acknowledge,
// holds SCL after received bytes, and streams registers out in read mode.
// Assumes conditioned inputs from i2cs_lines and a stable stretch_len
// while a transfer is in progress.
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h3A,
    parameter int NREG  = 8,
    parameter int STR_W = 8,
    localparam int PW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [STR_W-1:0] stretch_len,
    input  logic [7:0]       rdata,
    output logic [PW-1:0]    raddr,
    output logic             we,
    output logic [PW-1:0]    waddr,
    output logic [7:0]       wdata,
    output logic             scl_oe,
    output logic             sda_oe
);
    phase_t           ph;
    logic [3:0]       bitc;       // clock rises seen in the current byte
    logic [7:0]       rx_sh;      // received byte shifter
    logic [7:0]       tx_sh;      // transmit byte shifter, MSB on the wire
    logic             is_addr;    // current received byte is the address
    logic             rd_mode;    // transaction direction from address bit 0
    logic             ptr_set;    // pointer byte already taken this transaction
    logic             mack;       // master acknowledged last sent byte
    logic [PW-1:0]    ptr;
    logic [STR_W-1:0] hold;

    assign raddr = ptr;

    // Main protocol sequencer; START and STOP override any phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            bitc    <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            ptr_set <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            hold    <= '0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            we <= 1'b0;
            if (start_det) begin
                ph      <= PH_RECV;
                bitc    <= '0;
                is_addr <= 1'b1;
                ptr_set <= 1'b0;
                scl_oe  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                ph     <= PH_IDLE;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (ph)
                    PH_RECV: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[6:0], sda_s};
                            bitc  <= bitc + 1'b1;
                        end else if (scl_fall && bitc == 4'd8) begin
                            bitc <= '0;
                            if (is_addr) begin
                                if (rx_sh[7:1] == OWN_ADDR) begin
                                    ph      <= PH_ACK;
                                    sda_oe  <= 1'b1;
                                    rd_mode <= rx_sh[0];
                                end else begin
                                    ph <= PH_SKIP;
                                end
                            end else begin
                                ph     <= PH_ACK;
                                sda_oe <= 1'b1;
                                if (!ptr_set) begin
                                    ptr     <= rx_sh[PW-1:0];
                                    ptr_set <= 1'b1;
                                end else begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= rx_sh;
                                    ptr   <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            is_addr <= 1'b0;
                            if (rd_mode) begin
                                tx_sh  <= rdata;
                                sda_oe <= ~rdata[7];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                            if (stretch_len != '0) begin
                                scl_oe <= 1'b1;
                                hold   <= stretch_len;
                                ph     <= PH_HOLD;
                            end else begin
                                ph <= rd_mode ? PH_SEND : PH_RECV;
                            end
                        end
                    end
                    PH_HOLD: begin
                        if (hold == {{(STR_W-1){1'b0}}, 1'b1}) begin
                            scl_oe <= 1'b0;
                            ph     <= rd_mode ? PH_SEND : PH_RECV;
                        end else begin
                            hold <= hold - 1'b1;
                        end
                    end
                    PH_SEND: begin
                        if (scl_rise) begin
                            bitc <= bitc + 1'b1;
                        end else if (scl_fall) begin
                            if (bitc == 4'd8) begin
                                bitc   <= '0;
                                sda_oe <= 1'b0;
                                ph     <= PH_MACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx_sh  <= rdata;
                                sda_oe <= ~rdata[7];
                                ptr    <= ptr + 1'b1;
                                ph     <= PH_SEND;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    PH_IDLE, PH_SKIP: begin
                        scl_oe <= 1'b0;
                        sda_oe <= 1'b0;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    // Checker state: length of the current SCL hold run.
    logic [STR_W:0] oe_run;

    // Count consecutive cycles with the clock line held.
    always_ff @(posedge clk) begin
        if (!rst_n)      oe_run <= '0;
        else if (scl_oe) oe_run <= oe_run + 1'b1;
        else             oe_run <= '0;
    end

    // R4: a hold never lasts longer than the programmed length.
    a_r4_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> oe_run < {1'b0, stretch_len});

    // R9: no START can be seen while the slave keeps SCL low.
    a_r9_no_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && $past(scl_oe) |-> !start_det);

    // R10: a STOP releases both lines on the next cycle.
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe && !scl_oe);

    // R1: the data-line drive only changes while the clock line is low.
    a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R2: an unaddressed slave keeps both lines released.
    a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_SKIP && $past(ph == PH_SKIP) |-> !sda_oe && !scl_oe);

endmodule

// File: rtl/i2c_regbank_slave.sv
// Top of the I2C register-bank slave: line conditioner, protocol controller
// and register bank. Assumes an external wired-AND bus where scl_oe/sda_oe
// high pull the respective line low, and a clk far faster than SCL.
module i2c_regbank_slave #(
    parameter logic [6:0] OWN_ADDR    = 7'h3A,
    parameter int         NREG        = 8,
    parameter int         STR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [STR_W-1:0] stretch_len,
    output logic             scl_oe,
    output logic             sda_oe
);
    localparam int PW = $clog2(NREG);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          we;
    logic [PW-1:0] waddr, raddr;
    logic [7:0]    wdata, rdata;

    i2cs_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_ctrl #(.OWN_ADDR(OWN_ADDR), .NREG(NREG), .STR_W(STR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .stretch_len (stretch_len),
        .rdata       (rdata),
        .raddr       (raddr),
        .we          (we),
        .waddr       (waddr),
        .wdata       (wdata),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    i2cs_bank #(.NREG(NREG), .DW(8)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

endmodule

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
// Directed bench: a bus master model built from tasks, a wired-AND bus,
// and a reference model of the register bank and pointer.
module tb_i2c_regbank_slave;
    localparam int         HP = 16;
    localparam logic [6:0] ME = 7'h3A;
    localparam logic [7:0] AW = {ME, 1'b0};
    localparam logic [7:0] AR = {ME, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [7:0] stretch_len = 8'd10;
    logic       scl_oe, sda_oe;
    logic       scl_bus, sda_bus;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_regbank_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_bus),
        .sda_i       (sda_bus),
        .stretch_len (stretch_len),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    int         checks = 0;
    int         errors = 0;
    logic [7:0] mm [8];
    logic [2:0] mp = 3'd0;
    logic [7:0] wb [8];

    // Hold-run monitor at the port: counts runs and runs of the wrong length.
    int runs = 0, bad_len = 0, run_len = 0, sda_cyc = 0;
    always @(negedge clk) begin
        if (scl_oe) run_len++;
        else if (run_len != 0) begin
            runs++;
            if (run_len != int'(stretch_len)) bad_len++;
            run_len = 0;
        end
        if (sda_oe) sda_cyc++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); m_sda = b;
        wait_clk(HP); scl_up(); wait_clk(HP);
        m_scl = 1'b0; wait_clk(HP);
    endtask

    task automatic bit_in(output logic b);
        @(negedge clk); m_sda = 1'b1;
        wait_clk(HP); scl_up(); wait_clk(HP / 2);
        b = sda_bus;
        wait_clk(HP / 2);
        m_scl = 1'b0; wait_clk(HP);
    endtask

    task automatic m_start();
        @(negedge clk); m_sda = 1'b1;
        wait_clk(HP); scl_up(); wait_clk(HP);
        m_sda = 1'b0; wait_clk(HP);
        m_scl = 1'b0; wait_clk(HP);
    endtask

    task automatic m_stop();
        @(negedge clk); m_sda = 1'b0;
        wait_clk(HP); scl_up(); wait_clk(HP);
        m_sda = 1'b1; wait_clk(HP);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    // Write transaction: pointer byte then n bytes from wb.
    task automatic wr_txn(input logic [7:0] p, input int n);
        logic ack;
        m_start();
        wbyte(AW, ack); check("R1 write address ack", ack, 1);
        wbyte(p, ack);  check("R3 pointer byte ack", ack, 1);
        mp = p[2:0];
        for (int i = 0; i < n; i++) begin
            wbyte(wb[i], ack); check("R3 data byte ack", ack, 1);
            mm[mp] = wb[i];
            mp = mp + 3'd1;
        end
        m_stop();
    endtask

    // Set pointer, repeated START, read n bytes (last one not acknowledged).
    task automatic ptr_read(input logic [7:0] p, input int n, input string req);
        logic ack;
        logic [7:0] v;
        m_start();
        wbyte(AW, ack); check("R1 write address ack", ack, 1);
        wbyte(p, ack);  check("R3 pointer byte ack", ack, 1);
        mp = p[2:0];
        m_start();
        wbyte(AR, ack); check("R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            check(req, v, mm[mp]);
            mp = mp + 3'd1;
        end
        m_stop();
    endtask

    // Fresh read transaction from the retained pointer.
    task automatic fresh_read(input int n, input string req);
        logic ack;
        logic [7:0] v;
        m_start();
        wbyte(AR, ack); check("R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            check(req, v, mm[mp]);
            mp = mp + 3'd1;
        end
        m_stop();
    endtask

    task automatic t_reset_state();
        check("R11 scl_oe after reset", scl_oe, 0);
        check("R11 sda_oe after reset", sda_oe, 0);
        ptr_read(8'd0, 8, "R11 register reset value");
    endtask

    task automatic t_burst_write();
        wb[0] = 8'hA0; wb[1] = 8'hA1; wb[2] = 8'hA2;
        wr_txn(8'd2, 3);
        ptr_read(8'd2, 3, "R5 repeated-start readback");
    endtask

    task automatic t_wrap_read();
        wb[0] = 8'h66; wb[1] = 8'h77; wb[2] = 8'h88; wb[3] = 8'h99;
        wr_txn(8'd6, 4);
        wr_txn(8'd6, 0);
        fresh_read(5, "R6 R7 fresh read with wrap");
    endtask

    task automatic t_nack_release();
        logic ack, b;
        logic [7:0] v, tail;
        m_start();
        wbyte(AW, ack); check("R1 write address ack", ack, 1);
        wbyte(8'd3, ack); check("R3 pointer byte ack", ack, 1);
        mp = 3'd3;
        m_start();
        wbyte(AR, ack); check("R1 read address ack", ack, 1);
        rbyte(v, 1'b0);
        check("R8 byte before NACK", v, mm[mp]);
        mp = mp + 3'd1;
        check("R8 SDA released after NACK", sda_oe, 0);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            tail[i] = b;
        end
        check("R8 clocks after NACK read ones", tail, 8'hFF);
        m_stop();
    endtask

    task automatic t_wrong_addr();
        logic ack;
        int s0, r0;
        s0 = sda_cyc; r0 = runs;
        m_start();
        wbyte(8'h22, ack); check("R2 foreign address not acked", ack, 0);
        wbyte(8'h05, ack); check("R2 following byte not acked", ack, 0);
        m_stop();
        check("R2 SDA never driven", sda_cyc - s0, 0);
        check("R2 SCL never held", runs - r0, 0);
        fresh_read(1, "R2 later START served, pointer kept");
    endtask

    task automatic t_stretch();
        int r0, b0;
        stretch_len = 8'd25;
        r0 = runs; b0 = bad_len;
        wb[0] = 8'h5C;
        wr_txn(8'd5, 1);
        wait_clk(4);
        check("R4 hold count address+pointer+data", runs - r0, 3);
        check("R4 hold length matches setting", bad_len - b0, 0);
        r0 = runs;
        ptr_read(8'd5, 1, "R4 readback under hold");
        check("R4 hold after read address too", runs - r0, 3);
        check("R4 hold length on read path", bad_len - b0, 0);
        stretch_len = 8'd0;
        r0 = runs;
        wr_txn(8'd5, 0);
        check("R4 zero disables hold", runs - r0, 0);
        stretch_len = 8'd10;
    endtask

    task automatic t_false_start();
        logic ack;
        stretch_len = 8'd60;
        m_start();
        wbyte(AW, ack); check("R1 write address ack", ack, 1);
        wbyte(8'd1, ack); check("R3 pointer byte ack", ack, 1);
        mp = 3'd1;
        check("R9 slave still holding SCL", scl_oe, 1);
        @(negedge clk); m_sda = 1'b0;
        wait_clk(4);
        wbyte(AR, ack); check("R9 address+read taken as data, acked", ack, 1);
        mm[mp] = AR;
        mp = mp + 3'd1;
        m_stop();
        stretch_len = 8'd10;
        ptr_read(8'd1, 1, "R9 early-SDA byte stored as data");
    endtask

    task automatic t_no_start();
        logic ack;
        int r0;
        r0 = runs;
        @(negedge clk); m_scl = 1'b0;
        wait_clk(HP);
        wbyte(AW, ack); check("R10 byte without START not acked", ack, 0);
        check("R10 no hold without START", runs - r0, 0);
        m_stop();
        fresh_read(1, "R10 pointer unchanged");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) mm[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset_state();
        t_burst_write();
        t_wrap_read();
        t_nack_release();
        t_wrong_addr();
        t_stretch();
        t_false_start();
        t_no_start();
        wait_clk(10);
        finish_run();
    end

endmodule